// File: doc/BRIEF.md
# Prescaled Timer Counter Core

This block is the counting heart of a general purpose timer. An up-counter (32 bits by default) advances on count-enable ticks. Those ticks come from one of five source tick lines, all in the block's own clock domain, and pass through a programmable prescaler. When the oscillator source is selected, a second, smaller prescaler sits in front of the main one. Software drives the block through a small word-wide register port. It sets the enable, the counting mode, the clear-on-enable choice, the source select and both divide ratios, and it reads the count back.

Two counting modes are offered. In free-running mode the counter runs to its all-ones value and wraps to zero. In restart mode the counter goes back to zero once it has passed a programmed compare value. Each wrap from all-ones to zero sets a rollover flag, which is cleared by writing 1 to it and which, when enabled, drives the interrupt line. A self-clearing reset bit returns the whole block to its reset state.

Register map (word addresses): 0 control, 1 prescale, 2 status, 3 interrupt enable, 4 count (read only), 5 compare. Reads are combinational on `addr`. Writes take effect at the clock edge that samples `wr_en`.

Top module: `tmr_core`

## Requirements
- R1: After reset, the control, prescale, status, interrupt-enable, compare and count registers all read 0, and `irq` is 0.
- R2: Prescale bits [11:0] hold N-1, with N from 1 to 4096. The count advances once for every N ticks of the selected source.
- R3: Prescale bits [15:12] hold M-1, with M from 1 to 16. They divide oscillator ticks only, so with source 5 the count advances once per M×N oscillator ticks. With any other source this field has no effect.
- R4: Control bits [6:4] select the source: 0 off, 1 to 5 take `src_tick[0]` to `src_tick[4]` (1 peripheral, 2 high-frequency reference, 3 external pin, 4 low-frequency reference, 5 oscillator). Codes 6 and 7 supply no ticks. Ticks on lines that are not selected have no effect.
- R5: Control bit 7 is an oscillator-enable bit set by hardware. It reads 1 after a control write that selects source 5, and 0 after a control write that selects any other source. Software cannot write it directly.
- R6: With control bit 2 = 1 (free-running), the count goes from all-ones to 0 and ignores the compare register.
- R7: With control bit 2 = 0 (restart), a tick that arrives while the count equals the compare register sets the count to 0.
- R8: Control bit 0 is the enable. A control write that raises the enable from 0 to 1 with control bit 1 = 1 clears the count and both prescaler phases. The same write with bit 1 = 0 keeps the count.
- R9: While the block is disabled or the source is off, the count and both prescaler phases hold their values.
- R10: Status bit 0 is set when the count wraps from all-ones to 0. Writing 1 to it clears it, writing 0 leaves it set, and a wrap in the same cycle as a clear wins.
- R11: `irq` equals status bit 0 AND interrupt-enable bit 0.
- R12: Writing 1 to control bit 15 starts a software reset. The bit reads 1 during the following cycle, and after that every register and the count are back to their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| src_tick | input | 5 | Count-enable ticks, bit i belongs to source code i+1 |
| irq | output | 1 | Rollover interrupt request |

## Verification
The bench holds the prescaler at a known phase, disables the block, sends ticks, and then re-enables it. A design that lost the phase, or that counted while disabled, gives a different count after the next tick. It runs the oscillator path with both dividers set and then changes the source without re-enabling, which catches a design that applies the oscillator divider on every source or leaves the oscillator-enable bit set. It counts through the all-ones value in free-running mode with a compare value below it, so a design that restarts at the compare never reaches the maximum. In restart mode it checks that the count drops to zero only on the tick after the compare match. It reads control in the cycle right after a software-reset write and again one cycle later, so a reset bit that clears at once, or that never clears, is reported.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int N_SRC  = 5;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRESC = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMP   = 3'd5;

    typedef enum logic [2:0] {
        SRC_OFF  = 3'd0,
        SRC_PER  = 3'd1,
        SRC_HF   = 3'd2,
        SRC_EXT  = 3'd3,
        SRC_LF   = 3'd4,
        SRC_OSC  = 3'd5,
        SRC_RSV6 = 3'd6,
        SRC_RSV7 = 3'd7
    } src_e;

    typedef struct packed {
        logic swr;
        logic osc_en;
        src_e src;
        logic free;
        logic clr_mode;
        logic en;
    } ctrl_t;

    // Tick of the directly selected line; oscillator handled separately.
    function automatic logic pick_tick(src_e s, logic [N_SRC-1:0] t);
        case (s)
            SRC_PER: return t[0];
            SRC_HF:  return t[1];
            SRC_EXT: return t[2];
            SRC_LF:  return t[3];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        logic [DATA_W-1:0] v;
        v      = '0;
        v[0]   = c.en;
        v[1]   = c.clr_mode;
        v[2]   = c.free;
        v[6:4] = c.src;
        v[7]   = c.osc_en;
        v[15]  = c.swr;
        return v;
    endfunction
endpackage

// File: rtl/tmr_div.sv
module tmr_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick_in,
    input  logic [W-1:0] limit,
    output logic         tick_out
);
    logic [W-1:0] phase;

    assign tick_out = tick_in && (phase >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            phase <= '0;
        else if (tick_in)
            phase <= tick_out ? '0 : phase + 1'b1;
    end

    // R2: a divided tick starts a fresh phase
    a_r2_phase_restart: assert property (@(posedge clk) disable iff (rst)
        (tick_out && !clr) |=> (phase == '0));
    // R9: with no incoming tick the phase holds
    a_r9_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_in && !clr) |=> $stable(phase));
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int OSC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  src_e             src,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [PRE_W-1:0] main_lim,
    input  logic [OSC_W-1:0] osc_lim,
    output logic             cnt_tick
);
    logic osc_in, osc_out, main_in;

    assign osc_in  = en && (src == SRC_OSC) && src_tick[N_SRC-1];
    assign main_in = en && ((src == SRC_OSC) ? osc_out : pick_tick(src, src_tick));

    tmr_div #(.W(OSC_W)) i_osc_div (
        .clk(clk), .rst(rst), .clr(clr),
        .tick_in(osc_in), .limit(osc_lim), .tick_out(osc_out)
    );

    tmr_div #(.W(PRE_W)) i_main_div (
        .clk(clk), .rst(rst), .clr(clr),
        .tick_in(main_in), .limit(main_lim), .tick_out(cnt_tick)
    );

    // R9: disabled block produces no count tick
    a_r9_no_tick_off: assert property (@(posedge clk) disable iff (rst)
        (!en || src == SRC_OFF) |-> !cnt_tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             free,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic restart_hit;

    assign restart_hit = !free && (cnt == cmp);
    assign wrap        = tick && !clr && (cnt == MAXV);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= restart_hit ? '0 : cnt + 1'b1;
    end

    // R6: free-running count wraps to zero after all-ones
    a_r6_free_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && free && !clr && cnt == MAXV) |=> (cnt == '0));
    // R7: restart mode returns to zero after a compare match
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && !free && !clr && cnt == cmp) |=> (cnt == '0));
    // R8: clear-on-enable empties the count
    a_r8_clear_on_enable: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
    // R9: no tick, no change
    a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12,
    parameter int OSC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wrap,
    output ctrl_t             ctrl,
    output logic [PRE_W-1:0]  main_lim,
    output logic [OSC_W-1:0]  osc_lim,
    output logic [CNT_W-1:0]  cmp,
    output logic              clr_pulse,
    output logic              irq
);
    localparam int OSC_LO = 12;

    logic stat_rov, ien_rov, wr_ctrl, stat_w1c;

    assign wr_ctrl   = wr_en && (addr == A_CTRL);
    assign stat_w1c  = wr_en && (addr == A_STAT) && wdata[0];
    assign clr_pulse = wr_ctrl && wdata[0] && wdata[1] && !ctrl.en;
    assign irq       = stat_rov && ien_rov;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            main_lim <= '0;
            osc_lim  <= '0;
            cmp      <= '0;
            stat_rov <= 1'b0;
            ien_rov  <= 1'b0;
        end else begin
            if (wrap)
                stat_rov <= 1'b1;
            else if (stat_w1c)
                stat_rov <= 1'b0;
            if (wr_en) begin
                case (addr)
                    A_CTRL: begin
                        ctrl.en       <= wdata[0];
                        ctrl.clr_mode <= wdata[1];
                        ctrl.free     <= wdata[2];
                        ctrl.src      <= src_e'(wdata[6:4]);
                        ctrl.osc_en   <= (src_e'(wdata[6:4]) == SRC_OSC);
                        ctrl.swr      <= wdata[15];
                    end
                    A_PRESC: begin
                        main_lim <= wdata[PRE_W-1:0];
                        osc_lim  <= wdata[OSC_LO +: OSC_W];
                    end
                    A_IEN:   ien_rov <= wdata[0];
                    A_CMP:   cmp     <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = pack_ctrl(ctrl);
            A_PRESC: rdata = DATA_W'({osc_lim, main_lim});
            A_STAT:  rdata = DATA_W'(stat_rov);
            A_IEN:   rdata = DATA_W'(ien_rov);
            A_COUNT: rdata = DATA_W'(cnt);
            A_CMP:   rdata = DATA_W'(cmp);
            default: rdata = '0;
        endcase
    end

    // R12: software reset bit lasts exactly one cycle
    a_r12_swr_self_clear: assert property (@(posedge clk) disable iff (rst)
        ctrl.swr |=> !ctrl.swr);
    // R10: a wrap always leaves the flag set
    a_r10_rov_set: assert property (@(posedge clk) disable iff (rst)
        wrap |=> stat_rov);
    // R10: flag stays set unless cleared by a one
    a_r10_rov_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_rov && !stat_w1c) |=> stat_rov);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12,
    parameter int OSC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_SRC-1:0]  src_tick,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [PRE_W-1:0] main_lim;
    logic [OSC_W-1:0] osc_lim;
    logic [CNT_W-1:0] cmp, cnt;
    logic             clr_pulse, cnt_tick, wrap, rst_int;

    assign rst_int = rst || ctrl.swr;

    tmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .OSC_W(OSC_W)) i_regs (
        .clk(clk), .rst(rst_int), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt(cnt), .wrap(wrap), .ctrl(ctrl),
        .main_lim(main_lim), .osc_lim(osc_lim), .cmp(cmp),
        .clr_pulse(clr_pulse), .irq(irq)
    );

    tmr_prescale #(.PRE_W(PRE_W), .OSC_W(OSC_W)) i_pre (
        .clk(clk), .rst(rst_int), .clr(clr_pulse), .en(ctrl.en),
        .src(ctrl.src), .src_tick(src_tick), .main_lim(main_lim),
        .osc_lim(osc_lim), .cnt_tick(cnt_tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst(rst_int), .clr(clr_pulse), .tick(cnt_tick),
        .free(ctrl.free), .cmp(cmp), .cnt(cnt), .wrap(wrap)
    );
endmodule

// File: tb/test_tmr_core.sv
module test_tmr_core;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  src_tick = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [2:0]  a;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  ev_chk;

    tmr_core #(.CNT_W(CW)) i_tmr_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_tick(src_tick), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            @(ev_chk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_irq ? {31'b0, irq} : rdata;
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d actual %h expected %h", it.tag, it.a, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_irq = 1'b0; it.a = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        ->ev_chk;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.a = 3'd7; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
        ->ev_chk;
        @(negedge clk);
    endtask

    task automatic tick(input logic [4:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            src_tick = m;
            @(negedge clk);
        end
        src_tick = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(0, 32'h0, "R1 ctrl");
        rd(1, 32'h0, "R1 presc");
        rd(2, 32'h0, "R1 status");
        rd(4, 32'h0, "R1 count");
        chk_irq(1'b0, "R1 irq");

        // R2 divide by 3 on source 1, R4 unselected line ignored
        wr(1, 32'h0002);
        wr(0, 32'h0015);
        tick(5'b00001, 6);
        rd(4, 32'd2, "R2 count div3");
        tick(5'b00010, 3);
        rd(4, 32'd2, "R4 unselected ignored");
        rd(0, 32'h0015, "R5 osc bit clear");

        // R9 phase and count hold while disabled, R8 retain on enable
        tick(5'b00001, 2);
        wr(0, 32'h0014);
        tick(5'b00001, 5);
        rd(4, 32'd2, "R9 hold disabled");
        wr(0, 32'h0015);
        rd(4, 32'd2, "R8 retain on enable");
        tick(5'b00001, 1);
        rd(4, 32'd3, "R9 phase held");

        // R3 oscillator path, R8 clear on enable, R5 osc bit
        wr(0, 32'h0054);
        wr(1, 32'h1001);
        wr(0, 32'h0057);
        rd(4, 32'd0, "R8 clear on enable");
        rd(0, 32'h00D7, "R5 osc bit set");
        tick(5'b10000, 8);
        rd(4, 32'd2, "R3 osc div2 x main div2");
        tick(5'b00001, 4);
        rd(4, 32'd2, "R4 source1 ignored on osc");
        wr(0, 32'h0017);
        tick(5'b00001, 4);
        rd(4, 32'd4, "R3 osc divider bypassed");
        rd(0, 32'h0017, "R5 osc bit cleared");

        // R6 free-run wrap past compare, R10 flag, R11 irq
        wr(1, 32'h0);
        wr(5, 32'd10);
        tick(5'b00001, 251);
        rd(4, 32'd255, "R6 reach max");
        rd(2, 32'h0, "R10 no flag before wrap");
        tick(5'b00001, 1);
        rd(4, 32'd0, "R6 wrap to zero");
        rd(2, 32'h1, "R10 flag on wrap");
        chk_irq(1'b0, "R11 irq masked");
        wr(3, 32'h1);
        chk_irq(1'b1, "R11 irq enabled");
        wr(2, 32'h0);
        rd(2, 32'h1, "R10 write zero keeps");
        wr(2, 32'h1);
        rd(2, 32'h0, "R10 write one clears");
        chk_irq(1'b0, "R11 irq after clear");

        // R7 restart mode
        wr(0, 32'h0012);
        wr(0, 32'h0013);
        rd(4, 32'd0, "R8 clear restart");
        tick(5'b00001, 10);
        rd(4, 32'd10, "R7 at compare");
        tick(5'b00001, 1);
        rd(4, 32'd0, "R7 restart to zero");
        rd(2, 32'h0, "R7 no rollover flag");
        tick(5'b00001, 3);
        rd(4, 32'd3, "R7 counts again");

        // R12 software reset
        wr(0, 32'h8013);
        rd(0, 32'h8013, "R12 swr reads one");
        rd(0, 32'h0, "R12 ctrl after reset");
        rd(4, 32'h0, "R12 count after reset");
        rd(5, 32'h0, "R12 compare after reset");
        rd(3, 32'h0, "R12 irq enable after reset");

        wait (q.size() == 0);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule